// File: doc/BRIEF.md
# Burst-of-4 DDR Write Engine

This block is the write side of a separate-I/O synchronous memory that always moves data in bursts of four words. A write command (active-low enable plus a burst index) is sampled on a rising clock edge. Over the next two clock cycles the engine takes four data words from a double-data-rate input bus, one on each rising and each falling edge. Each word arrives with its own active-low byte mask.

The engine forms the two low address bits itself, counting linearly from zero. It merges each word into the storage array under that word's byte mask. A combinational lookup port into the same array stands for the concurrent read side. It lets the contents be observed at any time.

Commands may be issued back to back, one every two cycles. A command presented in the cycle right after an accepted command falls inside the burst and is discarded.

Top module: `burst4_ddr_wr`

## Requirements
- R1: When `wr_n` is low at a rising edge and the engine is not in the first data cycle of a burst, the command is accepted and `wr_addr` is captured as the burst index.
- R2: For a command accepted at rising edge T0, the four words are taken at rising edge T1, the falling edge after T1, rising edge T2 and the falling edge after T2. They are stored at word address {index, 2'b00}, {index, 2'b01}, {index, 2'b10} and {index, 2'b11} in that order.
- R3: `bw_n` is sampled together with each word. Where bit i is high, byte i (bits 8i+7:8i) of the addressed word keeps its earlier value; where it is low, that byte takes the new data.
- R4: A command presented at T1, the edge right after an accepted command, is ignored. A command presented at T2 is accepted, so bursts can run back to back.
- R5: While `wr_n` stays high (deselect), no burst starts, and the data and mask inputs leave the array unchanged.
- R6: The word for {index, 2'b00} is readable right after T1. The words for 2'b01 and 2'b10 are readable right after T2, and the word for 2'b11 right after T3.
- R7: `rd_data` returns the array word at `rd_addr` combinationally, independently of any write activity.
- R8: An asynchronous reset (`rst_n` low) ends any burst in progress. Words not yet committed are dropped, and words already committed remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands on rising edges, data on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write command |
| wr_addr | input | ABITS | Burst index |
| d | input | BYTES*BYTE_W | DDR write data |
| bw_n | input | BYTES | Active-low byte write mask, one bit per byte |
| rd_addr | input | ABITS+2 | Lookup word address |
| rd_data | output | BYTES*BYTE_W | Array word at rd_addr |

## Verification
For a command at rising edge T0, the first word of the burst is due on the lookup port one edge later. The second and third words are due two edges later, and the last word three edges later. The bench checks these three points separately, each just after its edge, and confirms that the words not yet due still hold their old values.

The table-driven run issues every command in the low clock phase before its edge. It drives each falling-edge word just after the preceding rising edge, and reads the array only after the final commit edge. Reset is applied one step after a rising data edge, so the expected split between committed and dropped words is fixed.

// File: rtl/burst4_ddr_wr.sv
module burst4_ddr_wr #(
  parameter int ABITS  = 4,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_n,
  input  logic [ABITS-1:0]          wr_addr,
  input  logic [BYTES*BYTE_W-1:0]   d,
  input  logic [BYTES-1:0]          bw_n,
  input  logic [ABITS+1:0]          rd_addr,
  output logic [BYTES*BYTE_W-1:0]   rd_data
);
  localparam int DW    = BYTES * BYTE_W;
  localparam int WA    = ABITS + 2;
  localparam int WORDS = 1 << WA;

  logic [DW-1:0]    mem [WORDS];
  logic [1:0]       wcnt;
  logic [ABITS-1:0] base;
  logic             fall_pend;
  logic [1:0]       fall_lsb;
  logic [ABITS-1:0] fall_base;
  logic [DW-1:0]    hold_d;
  logic [BYTES-1:0] hold_bw;

  wire accept = !wr_n && (wcnt != 2'd1);
  wire [WA-1:0] rise_wa = {base, (wcnt == 2'd1) ? 2'd0 : 2'd2};
  wire [WA-1:0] fall_wa = {fall_base, fall_lsb};

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [BYTES-1:0] keep);
    logic [DW-1:0] r;
    for (int i = 0; i < BYTES; i++)
      r[i*BYTE_W +: BYTE_W] = keep[i] ? old_w[i*BYTE_W +: BYTE_W]
                                      : new_w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt      <= 2'd0;
      base      <= '0;
      fall_pend <= 1'b0;
      fall_lsb  <= 2'd0;
      fall_base <= '0;
    end else begin
      wcnt      <= accept ? 2'd1 : ((wcnt == 2'd1) ? 2'd2 : 2'd0);
      if (accept) base <= wr_addr;
      fall_pend <= (wcnt != 2'd0);
      fall_lsb  <= (wcnt == 2'd1) ? 2'd1 : 2'd3;
      fall_base <= base;
    end
  end

  always_ff @(negedge clk) begin
    hold_d  <= d;
    hold_bw <= bw_n;
  end

  always_ff @(posedge clk) begin
    if (wcnt != 2'd0)
      mem[rise_wa] <= merge(mem[rise_wa], d, bw_n);
    if (fall_pend)
      mem[fall_wa] <= merge(mem[fall_wa], hold_d, hold_bw);
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/burst4_ddr_wr_chk.sv
module burst4_ddr_wr_chk #(
  parameter int WA = 6,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_n,
  input logic [1:0]    wcnt,
  input logic          fall_pend,
  input logic [WA-1:0] rd_addr,
  input logic [DW-1:0] rd_data
);
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && wcnt != 2'd1) |=> (wcnt == 2'd1));
  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt == 2'd1) |=> (wcnt == 2'd2));
  // R5
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n && wcnt != 2'd1) |=> (wcnt == 2'd0));
  // R2
  fall_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != 2'd0) |=> fall_pend);
  // R7
  quiet_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt == 2'd0 && !fall_pend) |=> ($stable(rd_addr) -> $stable(rd_data)));
endmodule

bind burst4_ddr_wr burst4_ddr_wr_chk #(.WA(ABITS + 2), .DW(BYTES * BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wcnt(wcnt),
  .fall_pend(fall_pend), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_burst4_ddr_wr.sv
`timescale 1ns/100ps
module tb_burst4_ddr_wr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_n = 1'b1;
  logic [3:0]  wr_addr = '0;
  logic [15:0] d = '0;
  logic [1:0]  bw_n = '0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  burst4_ddr_wr dut (.clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_addr(wr_addr),
                     .d(d), .bw_n(bw_n), .rd_addr(rd_addr), .rd_data(rd_data));

  always #2.5 clk = ~clk;

  // {wr_n, index, rise data, rise mask, fall data, fall mask}
  localparam logic [40:0] STIM [10] = '{
    {1'b0, 4'd3, 16'hEEEE, 2'b00, 16'hEEEE, 2'b00},
    {1'b1, 4'd0, 16'h1111, 2'b00, 16'h2222, 2'b00},
    {1'b0, 4'd5, 16'h3333, 2'b00, 16'h4444, 2'b00},
    {1'b0, 4'd7, 16'h5555, 2'b00, 16'h6666, 2'b00},
    {1'b1, 4'd7, 16'h7777, 2'b00, 16'h8888, 2'b00},
    {1'b0, 4'd3, 16'hEEEE, 2'b00, 16'hEEEE, 2'b00},
    {1'b1, 4'd0, 16'hAAAA, 2'b01, 16'hBBBB, 2'b10},
    {1'b1, 4'd0, 16'hCCCC, 2'b11, 16'hDDDD, 2'b00},
    {1'b1, 4'd7, 16'hFFFF, 2'b00, 16'hFFFF, 2'b00},
    {1'b1, 4'd7, 16'hFFFF, 2'b00, 16'hFFFF, 2'b00}
  };
  // {word address, expected data}
  localparam logic [21:0] EXPV [12] = '{
    {6'h0C, 16'hAA11}, {6'h0D, 16'h22BB}, {6'h0E, 16'h3333}, {6'h0F, 16'hDDDD},
    {6'h14, 16'h5555}, {6'h15, 16'h6666}, {6'h16, 16'h7777}, {6'h17, 16'h8888},
    {6'h1C, 16'h7770}, {6'h1D, 16'h7771}, {6'h1E, 16'h7772}, {6'h1F, 16'h7773}
  };

  task automatic cyc(input logic [40:0] v);
    @(negedge clk); #1;
    wr_n = v[40]; wr_addr = v[39:36]; d = v[35:20]; bw_n = v[19:18];
    @(posedge clk); #1;
    d = v[17:2]; bw_n = v[1:0];
  endtask

  task automatic idle();
    cyc({1'b1, 4'd0, 16'hFFFF, 2'b00, 16'hFFFF, 2'b00});
  endtask

  task automatic wr_burst(input logic [3:0] idx, input logic [15:0] b0, b1, b2, b3);
    cyc({1'b0, idx, 16'h0, 2'b00, 16'h0, 2'b00});
    cyc({1'b1, 4'd0, b0, 2'b00, b1, 2'b00});
    cyc({1'b1, 4'd0, b2, 2'b00, b3, 2'b00});
    idle();
    idle();
  endtask

  task automatic chk(input logic [5:0] a, input logic [15:0] exp, input string req);
    rd_addr = a;
    #0.1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0h: got %h expected %h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R5: after reset, deselect cycles with live data write nothing
    wr_burst(4'd1, 16'h0AB0, 16'h0AB1, 16'h0AB2, 16'h0AB3);
    cyc({1'b1, 4'd1, 16'h5A5A, 2'b00, 16'hA5A5, 2'b00});
    cyc({1'b1, 4'd1, 16'h5A5A, 2'b00, 16'hA5A5, 2'b00});
    idle();
    chk(6'h04, 16'h0AB0, "R5");
    chk(6'h07, 16'h0AB3, "R5");

    // Prefill index 7 (target of the ignored command)
    wr_burst(4'd7, 16'h7770, 16'h7771, 16'h7772, 16'h7773);

    // R1 R2 R3 R4 R7: vector table
    for (int i = 0; i < 10; i++) cyc(STIM[i]);
    idle();
    for (int i = 0; i < 12; i++)
      chk(EXPV[i][21:16], EXPV[i][15:0], i < 4 ? "R3" : (i < 8 ? "R4" : "R4_ignored"));

    // R6: commit timing, index 2
    wr_burst(4'd2, 16'h0100, 16'h0101, 16'h0102, 16'h0103);
    cyc({1'b0, 4'd2, 16'h0, 2'b00, 16'h0, 2'b00});
    chk(6'h08, 16'h0100, "R6 before T1");
    cyc({1'b1, 4'd0, 16'hA0A0, 2'b00, 16'hA1A1, 2'b00});
    chk(6'h08, 16'hA0A0, "R6 T1");
    chk(6'h09, 16'h0101, "R6 T1");
    cyc({1'b1, 4'd0, 16'hA2A2, 2'b00, 16'hA3A3, 2'b00});
    chk(6'h09, 16'hA1A1, "R6 T2");
    chk(6'h0A, 16'hA2A2, "R6 T2");
    chk(6'h0B, 16'h0103, "R6 T2");
    idle();
    chk(6'h0B, 16'hA3A3, "R6 T3");

    // R8: reset mid-burst, index 9
    wr_burst(4'd9, 16'h9000, 16'h9001, 16'h9002, 16'h9003);
    cyc({1'b0, 4'd9, 16'h0, 2'b00, 16'h0, 2'b00});
    cyc({1'b1, 4'd0, 16'hC0C0, 2'b00, 16'hC1C1, 2'b00});
    rst_n = 1'b0;
    wr_n = 1'b1;
    d = 16'hC2C2;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle();
    idle();
    chk(6'h24, 16'hC0C0, "R8");
    chk(6'h25, 16'h9001, "R8");
    chk(6'h26, 16'h9002, "R8");
    chk(6'h27, 16'h9003, "R8");

    // R1 after reset: a fresh command is accepted
    wr_burst(4'd9, 16'hD0D0, 16'hD1D1, 16'hD2D2, 16'hD3D3);
    chk(6'h24, 16'hD0D0, "R1");
    chk(6'h27, 16'hD3D3, "R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule